// File: doc/BRIEF.md
# Framed Link Transmit Generator

This block produces the transmit byte stream of a framed serial link at one byte per clock of the 125 MHz byte clock. It feeds an 8b/10b coder, so each byte comes with a flag that marks it as a control character. Frames follow one another with no gap. Every frame is 50 bytes long. It opens with a timing marker character and a protocol identifier byte. Four 12-byte packets follow. Each packet holds an address byte, ten payload bytes and a control byte. The control byte carries two parity bits that the block computes itself.

The marker character carries a timing hierarchy. A plain frame start uses one code. Separate codes flag each 2 µs tick, each millisecond and each second. The block keeps the frame, tick and millisecond counters that choose the code. A pulse-per-second input realigns them so that the next frame is a second frame. Packet contents come from a client through a request/accept handshake, one packet per slot. If the client offers nothing, the block sends an empty packet to the broadcast address.

Top module: `frame_tx_gen`

## Requirements
- R1: Every frame is 50 bytes. Byte 0 is the marker, byte 1 is the identifier, and then four packets follow, each made of an address byte, ten payload bytes and a control byte. `tx_k_o` is 1 for the marker byte only.
- R2: The marker code is 0x7C for a second frame, 0x5C for a millisecond frame, 0x3C for a 2 µs tick frame and 0xBC for any other frame. When several apply, the coarsest one wins.
- R3: A tick frame occurs every `FRAMES_PER_TICK` frames. Every `TICKS_PER_MS`-th tick is a millisecond. Every `MS_PER_SEC`-th millisecond is a second.
- R4: Byte 1 of every frame equals the parameter `PROTO_ID`, which defaults to 0xAA.
- R5: An accepted packet is sent with its address byte first. Its payload follows least significant byte first (`pld_data_i[7:0]` first, `pld_data_i[79:72]` last).
- R6: A slot with no offer is sent with address 0x80, ten zero payload bytes and a zero sideband nibble.
- R7: The control byte is {Po, Pe, 2'b00, sideband}. Po sits in bit 7, Pe in bit 6 and the sideband nibble in bits 3:0.
- R8: Po is the XOR of bits 1, 3, 5 and 7 of the address and of all payload bytes. Pe is the XOR of bits 0, 2, 4 and 6 of the same bytes. This gives even parity.
- R9: `pld_take_o` is high for exactly one cycle per packet slot, the cycle just before the address byte appears. The inputs are sampled at the end of that cycle.
- R10: A `pps_i` pulse, seen on any cycle, makes the next marker 0x7C and restarts all timing counters from that frame.
- R11: During reset `tx_data_o`, `tx_k_o` and `pld_take_o` are 0. The first frame after reset starts with 0x7C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_i | input | 1 | Pulse-per-second realign strobe |
| pld_take_o | output | 1 | Packet slot open; inputs are sampled at the end of this cycle |
| pld_valid_i | input | 1 | Client offers a packet for this slot |
| pld_addr_i | input | 8 | Destination address of the offered packet |
| pld_data_i | input | 80 | Ten payload bytes, byte 0 in bits 7:0 |
| pld_side_i | input | 4 | Sideband nibble for the control byte |
| tx_data_o | output | 8 | Transmit byte |
| tx_k_o | output | 1 | Byte is a control character |

## Verification
If the byte position drifts, the identifier byte or the address-slot strobe shows up in the wrong cycle, and the very next frame exposes this. If the timing counters are wrong, the marker code changes on the first tick frame that follows, which is at most `FRAMES_PER_TICK` frames later. The bench compares every output on every cycle against a behavioural model. So if a packet register is corrupted or the parity logic fails, the first affected data or control byte shows it, within the same packet. A lost PPS event is visible at the next frame start.

// File: rtl/ftx_pkg.sv
// Package: shared constants and the byte-sequencer state type of the
// framed link transmit generator.
package ftx_pkg;
    localparam logic [7:0] K_SOF    = 8'hBC;
    localparam logic [7:0] K_TICK   = 8'h3C;
    localparam logic [7:0] K_MSEC   = 8'h5C;
    localparam logic [7:0] K_SEC    = 8'h7C;
    localparam logic [7:0] ADDR_NUL = 8'h80;

    typedef enum logic [2:0] {
        ST_MARK,
        ST_PROTO,
        ST_ADDR,
        ST_DATA,
        ST_CTRL
    } ftx_state_e;
endpackage

// File: rtl/ftx_timebase.sv
// Module: ftx_timebase
// Keeps the frame/tick/millisecond phase and picks the marker for the
// frame that starts at the next edge where frame_start_i is high.
// Assumes frame_start_i is high for one cycle per frame. A PPS pulse
// on any cycle forces the next frame to phase zero (second marker).
module ftx_timebase #(
    parameter int FRAMES_PER_TICK = 5,
    parameter int TICKS_PER_MS    = 500,
    parameter int MS_PER_SEC      = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pps_i,
    input  logic       frame_start_i,
    output logic [7:0] marker_o
);
    import ftx_pkg::*;

    localparam int FW = $clog2(FRAMES_PER_TICK > 1 ? FRAMES_PER_TICK : 2);
    localparam int TW = $clog2(TICKS_PER_MS > 1 ? TICKS_PER_MS : 2);
    localparam int MW = $clog2(MS_PER_SEC > 1 ? MS_PER_SEC : 2);

    logic [FW-1:0] frm_q, frm_eff;
    logic [TW-1:0] tck_q, tck_eff;
    logic [MW-1:0] ms_q, ms_eff;
    logic          pps_pend_q;
    logic          realign;

    // Effective phase of the frame about to start, PPS applied.
    always_comb begin
        realign = pps_pend_q | pps_i;
        frm_eff = realign ? '0 : frm_q;
        tck_eff = realign ? '0 : tck_q;
        ms_eff  = realign ? '0 : ms_q;
    end

    // Marker choice, coarsest flag first.
    always_comb begin
        if (frm_eff == '0 && tck_eff == '0 && ms_eff == '0) marker_o = K_SEC;
        else if (frm_eff == '0 && tck_eff == '0)            marker_o = K_MSEC;
        else if (frm_eff == '0)                             marker_o = K_TICK;
        else                                                marker_o = K_SOF;
    end

    // Phase counters advance once per frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= '0;
            tck_q <= '0;
            ms_q  <= '0;
        end else if (frame_start_i) begin
            if (frm_eff == FW'(FRAMES_PER_TICK - 1)) begin
                frm_q <= '0;
                if (tck_eff == TW'(TICKS_PER_MS - 1)) begin
                    tck_q <= '0;
                    ms_q  <= (ms_eff == MW'(MS_PER_SEC - 1)) ? '0 : ms_eff + 1'b1;
                end else begin
                    tck_q <= tck_eff + 1'b1;
                    ms_q  <= ms_eff;
                end
            end else begin
                frm_q <= frm_eff + 1'b1;
                tck_q <= tck_eff;
                ms_q  <= ms_eff;
            end
        end
    end

    // Holds a PPS seen between frame starts until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)             pps_pend_q <= 1'b0;
        else if (frame_start_i) pps_pend_q <= 1'b0;
        else if (pps_i)         pps_pend_q <= 1'b1;
    end
endmodule

// File: rtl/ftx_parity.sv
// Module: ftx_parity
// Combinational split parity over NBYTES bytes: odd_o is the XOR of
// bit positions 1,3,5,7 of every byte, even_o of positions 0,2,4,6.
module ftx_parity #(
    parameter int NBYTES = 11
) (
    input  logic [NBYTES*8-1:0] bytes_i,
    output logic                odd_o,
    output logic                even_o
);
    logic [NBYTES-1:0] odd_b, even_b;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Per-byte partial parities.
        assign odd_b[b]  = ^{bytes_i[b*8+7], bytes_i[b*8+5], bytes_i[b*8+3], bytes_i[b*8+1]};
        assign even_b[b] = ^{bytes_i[b*8+6], bytes_i[b*8+4], bytes_i[b*8+2], bytes_i[b*8+0]};
    end

    assign odd_o  = ^odd_b;
    assign even_o = ^even_b;
endmodule

// File: rtl/ftx_seq.sv
// Module: ftx_seq
// Byte-slot sequencer: marker, identifier, then NPKT packets of
// address, PLD_BYTES payload bytes and control. The state names the
// byte that is emitted at the next clock edge.
module ftx_seq #(
    parameter int NPKT      = 4,
    parameter int PLD_BYTES = 10
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    output ftx_pkg::ftx_state_e                   state_o,
    output logic [$clog2(PLD_BYTES)-1:0]          idx_o,
    output logic                                  frame_start_o,
    output logic                                  take_o
);
    import ftx_pkg::*;

    localparam int IW = $clog2(PLD_BYTES);
    localparam int PW = $clog2(NPKT > 1 ? NPKT : 2);

    ftx_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic [PW-1:0] pkt_q;

    // Walks through the byte slots of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_MARK;
            idx_q <= '0;
            pkt_q <= '0;
        end else begin
            case (st_q)
                ST_MARK:  st_q <= ST_PROTO;
                ST_PROTO: st_q <= ST_ADDR;
                ST_ADDR: begin
                    st_q  <= ST_DATA;
                    idx_q <= '0;
                end
                ST_DATA: begin
                    if (idx_q == IW'(PLD_BYTES - 1)) st_q <= ST_CTRL;
                    else                             idx_q <= idx_q + 1'b1;
                end
                ST_CTRL: begin
                    if (pkt_q == PW'(NPKT - 1)) begin
                        pkt_q <= '0;
                        st_q  <= ST_MARK;
                    end else begin
                        pkt_q <= pkt_q + 1'b1;
                        st_q  <= ST_ADDR;
                    end
                end
                default: st_q <= ST_MARK;
            endcase
        end
    end

    assign state_o       = st_q;
    assign idx_o         = idx_q;
    assign frame_start_o = (st_q == ST_MARK) && rst_n;
    assign take_o        = (st_q == ST_ADDR) && rst_n;
endmodule

// File: rtl/frame_tx_gen.sv
// Module: frame_tx_gen
// Continuous framed byte stream for an 8b/10b PCS: timing marker,
// identifier, NPKT packets with split parity in the control byte.
// Assumes one byte per clock with no back-pressure. Payloads come
// through a one-cycle take strobe; an empty slot goes to address 0x80.
module frame_tx_gen #(
    parameter int          FRAMES_PER_TICK = 5,
    parameter int          TICKS_PER_MS    = 500,
    parameter int          MS_PER_SEC      = 1000,
    parameter int          NPKT            = 4,
    parameter int          PLD_BYTES       = 10,
    parameter logic [7:0]  PROTO_ID        = 8'hAA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pps_i,
    output logic                   pld_take_o,
    input  logic                   pld_valid_i,
    input  logic [7:0]             pld_addr_i,
    input  logic [PLD_BYTES*8-1:0] pld_data_i,
    input  logic [3:0]             pld_side_i,
    output logic [7:0]             tx_data_o,
    output logic                   tx_k_o
);
    import ftx_pkg::*;

    localparam int IW = $clog2(PLD_BYTES);
    localparam int DW = PLD_BYTES * 8;

    ftx_state_e     state;
    logic [IW-1:0]  idx;
    logic           frame_start;
    logic [7:0]     marker;
    logic [7:0]     pkt_addr_q;
    logic [DW-1:0]  pkt_data_q;
    logic [3:0]     pkt_side_q;
    logic           par_odd, par_even;

    ftx_seq #(.NPKT(NPKT), .PLD_BYTES(PLD_BYTES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_o       (state),
        .idx_o         (idx),
        .frame_start_o (frame_start),
        .take_o        (pld_take_o)
    );

    ftx_timebase #(
        .FRAMES_PER_TICK (FRAMES_PER_TICK),
        .TICKS_PER_MS    (TICKS_PER_MS),
        .MS_PER_SEC      (MS_PER_SEC)
    ) u_tb (
        .clk           (clk),
        .rst_n         (rst_n),
        .pps_i         (pps_i),
        .frame_start_i (frame_start),
        .marker_o      (marker)
    );

    ftx_parity #(.NBYTES(PLD_BYTES + 1)) u_par (
        .bytes_i ({pkt_data_q, pkt_addr_q}),
        .odd_o   (par_odd),
        .even_o  (par_even)
    );

    // Latches the offered packet, or an empty one, in the address slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_addr_q <= '0;
            pkt_data_q <= '0;
            pkt_side_q <= '0;
        end else if (state == ST_ADDR) begin
            pkt_addr_q <= pld_valid_i ? pld_addr_i : ADDR_NUL;
            pkt_data_q <= pld_valid_i ? pld_data_i : '0;
            pkt_side_q <= pld_valid_i ? pld_side_i : '0;
        end
    end

    // Output byte register, one byte per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data_o <= '0;
            tx_k_o    <= 1'b0;
        end else begin
            tx_k_o <= (state == ST_MARK);
            case (state)
                ST_MARK:  tx_data_o <= marker;
                ST_PROTO: tx_data_o <= PROTO_ID;
                ST_ADDR:  tx_data_o <= pld_valid_i ? pld_addr_i : ADDR_NUL;
                ST_DATA:  tx_data_o <= pkt_data_q[int'(idx)*8 +: 8];
                ST_CTRL:  tx_data_o <= {par_odd, par_even, 2'b00, pkt_side_q};
                default:  tx_data_o <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ftx_checker.sv
// Module: ftx_checker
// Port-level properties of frame_tx_gen, bound to every instance.
// It accumulates the parity of each sent packet from the output bytes.
module ftx_checker #(
    parameter int         PLD_BYTES = 10,
    parameter logic [7:0] PROTO_ID  = 8'hAA
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pld_take_o,
    input logic                   pld_valid_i,
    input logic [7:0]             pld_addr_i,
    input logic [PLD_BYTES*8-1:0] pld_data_i,
    input logic [7:0]             tx_data_o,
    input logic                   tx_k_o
);
    logic       active;
    logic [4:0] pos;
    logic       acc_odd, acc_even;
    logic       b_odd, b_even;

    assign b_odd  = ^{tx_data_o[7], tx_data_o[5], tx_data_o[3], tx_data_o[1]};
    assign b_even = ^{tx_data_o[6], tx_data_o[4], tx_data_o[2], tx_data_o[0]};

    // Tracks the byte position inside the packet after each take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pos      <= '0;
            acc_odd  <= 1'b0;
            acc_even <= 1'b0;
        end else if (pld_take_o) begin
            active <= 1'b1;
            pos    <= '0;
        end else if (active) begin
            pos      <= pos + 1'b1;
            acc_odd  <= (pos == 0) ? b_odd  : acc_odd ^ b_odd;
            acc_even <= (pos == 0) ? b_even : acc_even ^ b_even;
            if (pos == 5'(PLD_BYTES + 1)) active <= 1'b0;
        end
    end

    // R1: the control-character flag only ever carries a marker code
    a_r1_k_is_marker: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k_o |-> (tx_data_o == 8'hBC || tx_data_o == 8'h3C ||
                    tx_data_o == 8'h5C || tx_data_o == 8'h7C));

    // R4: identifier byte follows each marker
    a_r4_proto_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k_o |=> (!tx_k_o && tx_data_o == PROTO_ID));

    // R9: the take strobe lasts one cycle
    a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        pld_take_o |=> !pld_take_o);

    // R5: an accepted address appears in the next byte
    a_r5_addr_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_take_o && pld_valid_i) |=> (tx_data_o == $past(pld_addr_i) && !tx_k_o));

    // R5: first payload byte follows the address
    a_r5_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_take_o && pld_valid_i) |=> ##1 (tx_data_o == $past(pld_data_i[7:0], 2)));

    // R6: an empty slot sends the broadcast address
    a_r6_empty_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_take_o && !pld_valid_i) |=> (tx_data_o == 8'h80));

    // R7 and R8: control byte layout and parity over the sent bytes
    a_r8_ctrl_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pos == 5'(PLD_BYTES + 1)) |->
            (tx_data_o[7] == acc_odd && tx_data_o[6] == acc_even && tx_data_o[5:4] == 2'b00));
endmodule

bind frame_tx_gen ftx_checker #(.PLD_BYTES(PLD_BYTES), .PROTO_ID(PROTO_ID)) u_ftx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pld_take_o  (pld_take_o),
    .pld_valid_i (pld_valid_i),
    .pld_addr_i  (pld_addr_i),
    .pld_data_i  (pld_data_i),
    .tx_data_o   (tx_data_o),
    .tx_k_o      (tx_k_o)
);

// File: tb/tb_frame_tx_gen.sv
// Bench: a behavioural model of the frame format, compared on every cycle.
module tb_frame_tx_gen;
    localparam int CLK_PERIOD = 8;
    localparam int FPT = 2;
    localparam int TPM = 3;
    localparam int MPS = 2;
    localparam int RUN_CYCLES = 3200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_i = 1'b0;
    logic        pld_take_o;
    logic        pld_valid_i = 1'b0;
    logic [7:0]  pld_addr_i = '0;
    logic [79:0] pld_data_i = '0;
    logic [3:0]  pld_side_i = '0;
    logic [7:0]  tx_data_o;
    logic        tx_k_o;

    int tests = 0;
    int fails = 0;

    frame_tx_gen #(
        .FRAMES_PER_TICK(FPT), .TICKS_PER_MS(TPM), .MS_PER_SEC(MPS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .pld_take_o(pld_take_o),
        .pld_valid_i(pld_valid_i), .pld_addr_i(pld_addr_i), .pld_data_i(pld_data_i),
        .pld_side_i(pld_side_i), .tx_data_o(tx_data_o), .tx_k_o(tx_k_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int          pos = 0;
    int          f = 0, t = 0, m = 0;
    bit          pend = 0;
    logic [7:0]  exp_data = 0;
    logic        exp_k = 0;
    logic [7:0]  m_addr = 0;
    logic [79:0] m_data = 0;
    logic [3:0]  m_side = 0;
    string       tag = "R11";
    int          frames = 0;

    function automatic bit is_addr_slot(int p);
        return (p >= 2) && ((p - 2) % 12 == 0);
    endfunction

    // Model: byte expected after each edge, from inputs only
    always @(posedge clk) begin
        if (!rst_n) begin
            pos = 0; f = 0; t = 0; m = 0; pend = 0;
            exp_data = 0; exp_k = 0; tag = "R11";
        end else begin
            exp_k = 0;
            if (pos == 0) begin
                if (pend || pps_i) begin f = 0; t = 0; m = 0; end
                pend = 0;
                if (f == 0 && t == 0 && m == 0) exp_data = 8'h7C;
                else if (f == 0 && t == 0)      exp_data = 8'h5C;
                else if (f == 0)                exp_data = 8'h3C;
                else                            exp_data = 8'hBC;
                exp_k = 1;
                tag = "R2/R3/R10";
                f++;
                if (f == FPT) begin
                    f = 0; t++;
                    if (t == TPM) begin t = 0; m++; if (m == MPS) m = 0; end
                end
                frames++;
            end else begin
                if (pps_i) pend = 1;
                if (pos == 1) begin
                    exp_data = 8'hAA; tag = "R4";
                end else begin
                    int r;
                    r = (pos - 2) % 12;
                    if (r == 0) begin
                        if (pld_valid_i) begin
                            m_addr = pld_addr_i; m_data = pld_data_i; m_side = pld_side_i;
                            tag = "R5";
                        end else begin
                            m_addr = 8'h80; m_data = '0; m_side = '0;
                            tag = "R6";
                        end
                        exp_data = m_addr;
                    end else if (r <= 10) begin
                        exp_data = m_data[(r-1)*8 +: 8];
                        tag = (m_addr == 8'h80 && m_data == 0) ? "R6" : "R5";
                    end else begin
                        bit po, pe;
                        po = ^{m_addr[7], m_addr[5], m_addr[3], m_addr[1]};
                        pe = ^{m_addr[6], m_addr[4], m_addr[2], m_addr[0]};
                        for (int j = 0; j < 10; j++) begin
                            po ^= ^{m_data[j*8+7], m_data[j*8+5], m_data[j*8+3], m_data[j*8+1]};
                            pe ^= ^{m_data[j*8+6], m_data[j*8+4], m_data[j*8+2], m_data[j*8+0]};
                        end
                        exp_data = {po, pe, 2'b00, m_side};
                        tag = "R7/R8";
                    end
                end
            end
            pos = (pos + 1) % 50;
        end
    end

    // Compare all outputs away from the edge; R1 and R9 framing covered too
    always @(negedge clk) begin
        logic exp_take;
        exp_take = rst_n && is_addr_slot(pos);
        tests++;
        if (tx_data_o !== exp_data || tx_k_o !== exp_k) begin
            fails++;
            $display("FAIL %s/R1: data=%02h k=%0b expected data=%02h k=%0b",
                     tag, tx_data_o, tx_k_o, exp_data, exp_k);
        end
        tests++;
        if (pld_take_o !== exp_take) begin
            fails++;
            $display("FAIL R9: take=%0b expected %0b", pld_take_o, exp_take);
        end
    end

    // Stimulus: mixed, all-empty and all-full phases, PPS pulses, a second reset
    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values held while rst_n is low (compared above each cycle)
        rst_n = 1'b1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            if (c < 800)       pld_valid_i = ($urandom % 10) < 7;
            else if (c < 1300) pld_valid_i = 1'b0;
            else if (c < 1800) pld_valid_i = 1'b1;
            else               pld_valid_i = ($urandom % 2) == 1;
            pld_addr_i = (c % 97 == 5) ? 8'h00 : 8'($urandom);
            pld_data_i = {16'($urandom), $urandom, $urandom};
            pld_side_i = 4'($urandom);
            // R10: PPS on a frame-start cycle, mid-frame, and at random
            pps_i = (pos == 0 && frames == 7) || (c == 1111) || ($urandom % 900 == 0);
            rst_n = !(c >= 2400 && c < 2403);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not end, expected finish by %0d cycles", 200000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule